// File: doc/BRIEF.md
# Integer Adder with Condition Flags

This unit adds two integer operands of a configurable width (32 bits by default) for a shader-style arithmetic pipeline. Either operand may be replaced by its two's complement before the sum is formed. An extended mode adds one to the sum when the stored carry flag is set, so a wide addition can be split into several chained word operations. The result wraps modulo 2^WIDTH.

When a strobe marks the input valid, the sum is captured on the next rising clock edge and presented with a valid flag one cycle later. If the flag-write control is also high, four held condition bits are updated at the same edge: zero, sign, carry and overflow. The carry bit reports only the carry out of the two possibly negated operands, and never includes the extended carry-in. The overflow bit is set only when both operands are strictly positive as signed values and the result is negative. Saturating addition is not supported, and callers must not request it.

Top module: `iadd_flags_unit`

## Requirements
- R1: A synchronous active-high reset clears the valid output, the result register and all four flags to 0.
- R2: When in_vld is high, res_data one cycle later equals opa' + opb' + cin modulo 2^WIDTH. Here x' is -x when that operand's negate input is high and x otherwise. cin is the stored carry flag when ext_en is high and 0 otherwise. res_vld is high in that cycle.
- R3: When in_vld is low, res_vld is low on the next cycle and res_data keeps its value.
- R4: In extended mode the carry-in is the carry flag value held before the current edge, so chained operations propagate carry.
- R5: The zero flag (flags bit 0) is set when the WIDTH-bit result equals 0.
- R6: The sign flag (flags bit 1) equals the top bit of the result.
- R7: The carry flag (flags bit 2) is the carry out of opa' + opb' and excludes the extended carry-in.
- R8: The overflow flag (flags bit 3) is set when opa' > 0, opb' > 0 (signed) and the result is negative, and is 0 otherwise.
- R9: Flags change only on an edge where in_vld and flag_we are both high. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input operation strobe |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| neg_a | input | 1 | Negate first operand |
| neg_b | input | 1 | Negate second operand |
| ext_en | input | 1 | Add stored carry flag as carry-in |
| flag_we | input | 1 | Update condition flags |
| res_vld | output | 1 | Result valid, one cycle after in_vld |
| res_data | output | WIDTH | Registered sum |
| flags | output | 4 | {overflow, carry, sign, zero} |

## Verification
The bench tests carry-flag isolation by adding 0xFFFFFFFF + 0 with carry-in set. The result wraps to zero, yet the carry flag must stay 0. A design that folded the carry-in into the carry flag would report 1. Overflow is tested with operand pairs where one operand is zero or negative. A conventional signed-overflow detector would flag negative-plus-negative sums, which this rule must not do. Chained extended additions and writes with flag_we low check that the carry-in comes from the held flag and that the flags are not overwritten.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  localparam int FLAG_Z = 0;
  localparam int FLAG_S = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int NFLAGS = 4;

  typedef struct packed {
    logic ovf;
    logic cry;
    logic sgn;
    logic zro;
  } flags_t;
endpackage

// File: rtl/iadd_operand_prep.sv
module iadd_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             neg,
  output logic [WIDTH-1:0] prepped
);
  always_comb prepped = neg ? (~raw + {{(WIDTH-1){1'b0}}, 1'b1}) : raw;
endmodule

// File: rtl/iadd_core.sv
module iadd_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output iadd_pkg::flags_t fl
);
  logic [WIDTH:0] ab_wide;
  logic [WIDTH-1:0] total;
  logic a_pos, b_pos;

  always_comb begin
    ab_wide = {1'b0, a} + {1'b0, b};
    total   = ab_wide[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, cin};
    a_pos   = !a[WIDTH-1] && (a != '0);
    b_pos   = !b[WIDTH-1] && (b != '0);
    sum     = total;
    fl.zro  = (total == '0);
    fl.sgn  = total[WIDTH-1];
    fl.cry  = ab_wide[WIDTH];
    fl.ovf  = a_pos && b_pos && total[WIDTH-1];
  end
endmodule

// File: rtl/iadd_flags_unit.sv
module iadd_flags_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             neg_a,
  input  logic             neg_b,
  input  logic             ext_en,
  input  logic             flag_we,
  output logic             res_vld,
  output logic [WIDTH-1:0] res_data,
  output logic [3:0]       flags
);
  import iadd_pkg::*;

  logic [WIDTH-1:0] a_p, b_p, sum_c;
  flags_t fl_c, fl_q;
  logic cin;

  iadd_operand_prep #(.WIDTH(WIDTH)) u_prep_a (.raw(opa), .neg(neg_a), .prepped(a_p));
  iadd_operand_prep #(.WIDTH(WIDTH)) u_prep_b (.raw(opb), .neg(neg_b), .prepped(b_p));

  always_comb cin = ext_en && fl_q.cry;

  iadd_core #(.WIDTH(WIDTH)) u_core (.a(a_p), .b(b_p), .cin(cin), .sum(sum_c), .fl(fl_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_data <= '0;
      fl_q     <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) begin
        res_data <= sum_c;
        if (flag_we) fl_q <= fl_c;
      end
    end
  end

  always_comb flags = fl_q;

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!res_vld && $stable(res_data)));
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_vld && flag_we) |=> $stable(flags));
  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flag_we) |=> (flags[FLAG_Z] == (res_data == '0)));
  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flag_we) |=> (flags[FLAG_S] == res_data[WIDTH-1]));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flag_we && (a_p[WIDTH-1] || b_p[WIDTH-1])) |=> !flags[FLAG_V]);
  // R2
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
endmodule

// File: tb/tb_iadd_flags_unit.sv
module tb_iadd_flags_unit;
  localparam int W = 32;
  logic clk = 0, rst = 1;
  logic in_vld = 0, neg_a = 0, neg_b = 0, ext_en = 0, flag_we = 0;
  logic [W-1:0] opa = 0, opb = 0;
  logic res_vld;
  logic [W-1:0] res_data;
  logic [3:0] flags;
  int checks = 0, fails = 0;
  logic [3:0] mflags = 0;
  logic [W-1:0] mres = 0;

  iadd_flags_unit #(.WIDTH(W)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [W+4-1:0] model(input logic [W-1:0] a, b,
      input logic na, nb, ext, input logic cf);
    logic [W-1:0] ap, bp, s;
    logic [W:0] w;
    logic [3:0] f;
    ap = na ? -a : a;
    bp = nb ? -b : b;
    w = {1'b0, ap} + {1'b0, bp};
    s = w[W-1:0] + ((ext && cf) ? 1 : 0);
    f[0] = (s == 0);
    f[1] = s[W-1];
    f[2] = w[W];
    f[3] = ($signed(ap) > 0) && ($signed(bp) > 0) && s[W-1];
    return {f, s};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [W-1:0] a, b, input logic na, nb, ext, we, input string tag);
    logic [W+3:0] m;
    m = model(a, b, na, nb, ext, mflags[2]);
    @(negedge clk);
    opa = a; opb = b; neg_a = na; neg_b = nb; ext_en = ext; flag_we = we; in_vld = 1;
    @(negedge clk);
    in_vld = 0;
    mres = m[W-1:0];
    if (we) mflags = m[W+3:W];
    chk({tag, " R2 result"}, res_data, mres);
    chk({tag, " R2 valid"}, res_vld, 1);
    chk({tag, " flags R5 R6 R7 R8 R9"}, flags, mflags);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 reset vld", res_vld, 0);
    chk("R1 reset data", res_data, 0);
    chk("R1 reset flags", flags, 0);
    // R7 carry without carry-in, then R4 chained
    op(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, "R7 carry");
    op(32'h0, 32'h0, 0, 0, 1, 1, "R4 chain");
    op(32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1, "R7 set");
    op(32'hFFFF_FFFF, 32'h0, 0, 0, 1, 1, "R7 cin excluded");
    // R8
    op(32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1, "R8 ovf");
    op(32'h8000_0000, 32'h8000_0000, 0, 0, 0, 1, "R8 negneg");
    op(32'h0, 32'h8000_0000, 0, 0, 0, 1, "R8 zero op");
    op(32'h5, 32'h3, 1, 0, 0, 1, "R2 neg_a");
    op(32'h5, 32'h3, 1, 1, 0, 1, "R2 neg both");
    // R9
    op(32'h1, 32'h1, 0, 0, 0, 0, "R9 no we");
    // R3
    @(negedge clk);
    chk("R3 idle vld", res_vld, 0);
    chk("R3 idle data", res_data, mres);
    for (int i = 0; i < 300; i++)
      op($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "rand");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule